// File: doc/BRIEF.md
# Frame Length and Checksum Checker

This block sits after a serial deserializer and watches each received frame one byte at a time. A frame-start pulse clears its state. From then on it gives every byte a field label: one of the four header fields, payload data or the trailing checksum. The first header byte carries the payload size in 32-bit words. From it the block works out which byte index holds the checksum. It keeps a running XOR of the bytes and raises a checksum error when the checksum byte does not match the XOR of every byte before it.

When the deserializer reports the end pattern, the block compares the number of bytes it received with the number the size field promised. The expected count is the checksum index plus one. A mismatch raises a size error. All outputs are registered and appear one clock after the input that causes them.

Top module: `frame_len_xor_check`

## Requirements
- R1: While reset is asserted and on the first sample after it, `fld_vld`, `fld_type`, `cksum_err` and `size_err` are all 0.
- R2: Within a frame, bytes at index 0, 1, 2 and 3 are labelled with codes 0 (size), 1 (source address), 2 (destination address) and 3 (command).
- R3: Byte 0 of value v sets the checksum index to 4*(v+1). The byte at that index is labelled 5 (checksum). Every other byte at index 4 or above is labelled 4 (data). This includes bytes that arrive after the checksum.
- R4: `cksum_err` pulses together with the label of the checksum byte exactly when that byte differs from the XOR of all earlier bytes of the frame. It is 0 at every other time.
- R5: `frm_start` clears the byte count and the XOR, and sets the checksum index to 4, even in the middle of a frame. Bytes from before the restart affect neither labels nor checks.
- R6: `size_err` pulses one clock after `frm_end` exactly when the byte count differs from the checksum index plus one. A byte accepted in the `frm_end` cycle is counted. `size_err` is 0 at every other time.
- R7: A byte presented in the same cycle as `frm_start` is byte 0 of the new frame.
- R8: The byte count saturates at 2047 and never wraps. Long streams therefore stay labelled 4 and still report a size error at the end.
- R9: `fld_vld` is high exactly one clock after each accepted byte. `fld_type` is 0 whenever `fld_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A received byte is present on `byte_in` |
| byte_in | input | 8 | Received byte |
| frm_start | input | 1 | Start pattern seen; begin a new frame |
| frm_end | input | 1 | End pattern seen |
| fld_vld | output | 1 | Field label valid |
| fld_type | output | 3 | Field label code |
| cksum_err | output | 1 | Checksum mismatch on the checksum byte |
| size_err | output | 1 | Byte count disagrees with the size field at end |

## Verification
The assertions assume that the deserializer never reports a start pattern and an end pattern in the same cycle. They also assume the inputs settle away from the clock edge. The stimulus keeps to both. It pulses the start and end indications only in cycles of their own, except in the deliberate case where a start arrives together with a byte. Random frames vary the size field, insert idle gaps, corrupt checksums, drop or add bytes and restart in mid-frame. Directed cases cover the largest size field and a stream long enough to reach the counter's ceiling.

// File: rtl/frame_len_xor_check.sv
module frame_len_xor_check #(
  parameter int DW  = 8,
  parameter int CW  = 11,
  parameter int HDR = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_in,
  input  logic          frm_start,
  input  logic          frm_end,
  output logic          fld_vld,
  output logic [2:0]    fld_type,
  output logic          cksum_err,
  output logic          size_err
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [2:0]    TDAT = 3'd4;
  localparam logic [2:0]    TCHK = 3'd5;

  logic [CW-1:0] cnt_q, exp_q;
  logic [DW-1:0] acc_q;

  wire [CW-1:0] cnt_b = frm_start ? '0 : cnt_q;
  wire [CW-1:0] exp_b = frm_start ? CW'(HDR) : exp_q;
  wire [DW-1:0] acc_b = frm_start ? '0 : acc_q;

  wire          at_chk  = (cnt_b == exp_b);
  wire [2:0]    typ     = (cnt_b < CW'(HDR)) ? 3'(cnt_b) : (at_chk ? TCHK : TDAT);
  wire [CW-1:0] exp_new = (CW'(byte_in) + CW'(1)) * CW'(HDR);

  wire [CW-1:0] cnt_n = !byte_vld ? cnt_b : (cnt_b == CMAX ? cnt_b : cnt_b + CW'(1));
  wire [CW-1:0] exp_n = (byte_vld && cnt_b == '0) ? exp_new : exp_b;
  wire [DW-1:0] acc_n = byte_vld ? acc_b ^ byte_in : acc_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      exp_q     <= CW'(HDR);
      acc_q     <= '0;
      fld_vld   <= 1'b0;
      fld_type  <= 3'd0;
      cksum_err <= 1'b0;
      size_err  <= 1'b0;
    end else begin
      cnt_q     <= cnt_n;
      exp_q     <= exp_n;
      acc_q     <= acc_n;
      fld_vld   <= byte_vld;
      fld_type  <= byte_vld ? typ : 3'd0;
      cksum_err <= byte_vld && at_chk && (byte_in != acc_b);
      size_err  <= frm_end && (cnt_n != exp_n + CW'(1));
    end
  end

  AST_NO_START_END: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_start && frm_end)); // R6
  AST_TYPE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fld_type <= TCHK); // R2
  AST_IDLE_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    !fld_vld |-> fld_type == 3'd0); // R9
  AST_CKERR_ON_CHK: assert property (@(posedge clk) disable iff (!rst_n)
    cksum_err |-> fld_vld && fld_type == TCHK); // R4
  AST_FIRST_IS_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start && byte_vld |=> fld_vld && fld_type == 3'd0); // R7
  AST_SIZE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> $past(frm_end)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CMAX && !frm_start |=> cnt_q == CMAX); // R8
endmodule

// File: tb/tb_frame_len_xor_check.sv
`timescale 1ns/1ps
module tb_frame_len_xor_check;
  logic clk = 1'b0, rst_n = 1'b0;
  logic byte_vld = 1'b0, frm_start = 1'b0, frm_end = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic fld_vld, cksum_err, size_err;
  logic [2:0] fld_type;

  frame_len_xor_check dut (.clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .frm_start(frm_start), .frm_end(frm_end), .fld_vld(fld_vld), .fld_type(fld_type),
    .cksum_err(cksum_err), .size_err(size_err));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string ctx = "rand";
  int m_cnt = 0, m_exp = 4;
  logic [7:0] m_acc = 8'h00;

  function automatic logic [2:0] exp_type(int c, int e);
    if (c < 4) return 3'(c);
    return (c == e) ? 3'd5 : 3'd4;
  endfunction

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, ctx, act, expv, $time);
    end
  endtask

  task automatic step(bit v, logic [7:0] d, bit st, bit en);
    int c, e; logic [7:0] a;
    logic [2:0] et; bit ec, es;
    byte_vld = v; byte_in = d; frm_start = st; frm_end = en;
    c = st ? 0 : m_cnt; e = st ? 4 : m_exp; a = st ? 8'h00 : m_acc;
    et = v ? exp_type(c, e) : 3'd0;
    ec = v && (c == e) && (d != a);
    if (v) begin
      if (c == 0) e = 4 * (int'(d) + 1);
      a = a ^ d;
      if (c < 2047) c = c + 1;
    end
    es = en && (c != e + 1);
    m_cnt = c; m_exp = e; m_acc = a;
    @(posedge clk); @(negedge clk);
    byte_vld = 1'b0; frm_start = 1'b0; frm_end = 1'b0;
    chk("R9", int'(fld_vld), int'(v));
    chk((v && et < 4) ? "R2" : "R3", int'(fld_type), int'(et));
    chk("R4", int'(cksum_err), int'(ec));
    chk("R6", int'(size_err), int'(es));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic frame(int sz, int mode);
    int n; logic [7:0] x, b;
    n = 4 * (sz + 1) + (mode == 2 ? -2 : (mode == 3 ? 1 : 0));
    x = 8'h00;
    step(1'b0, 8'h00, 1'b1, 1'b0);
    for (int i = 0; i < n; i++) begin
      b = (i == 0) ? 8'(sz) : 8'($urandom);
      x ^= b;
      step(1'b1, b, 1'b0, 1'b0);
      if (mode == 4 && ($urandom % 3 == 0)) idle(1 + $urandom % 2);
      if (mode == 5 && i == 5) return;
    end
    b = (mode == 1) ? (x ^ 8'(1 + $urandom % 255)) : x;
    step(1'b1, b, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    idle(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog [%s] actual=timeout expected=finish", ctx);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    ctx = "R1";
    repeat (3) @(negedge clk);
    chk("R1", int'({fld_vld, fld_type, cksum_err, size_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'({fld_vld, fld_type, cksum_err, size_err}), 0);

    ctx = "directed";
    frame(0, 0);
    frame(1, 1);
    frame(0, 2);
    frame(2, 3);

    ctx = "R5";  // restart mid-frame, then a clean frame
    frame(3, 5);
    frame(1, 0);

    ctx = "R7";  // byte together with start
    step(1'b1, 8'h00, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, 8'h11 << i, 1'b0, 1'b0);
    step(1'b1, 8'h00 ^ 8'h11 ^ 8'h22 ^ 8'h44, 1'b0, 1'b0);
    step(1'b1, 8'h00 ^ 8'h11 ^ 8'h22 ^ 8'h44 ^ 8'h88, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b1);

    ctx = "max_size";
    frame(255, 0);

    ctx = "R8";  // stream past the counter ceiling
    step(1'b0, 8'h00, 1'b1, 1'b0);
    for (int i = 0; i < 2100; i++) step(1'b1, (i == 0) ? 8'hFF : 8'($urandom), 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b1);

    ctx = "rand";
    for (int k = 0; k < 300; k++) frame($urandom % 4, $urandom % 6);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule